// File: doc/BRIEF.md
# Asynchronous Slave FIFO Write Port with Packet Commit

This block is the device-side write port of a multi-channel slave FIFO. An external master drives it without a clock: it sets a FIFO select address and a byte on the data bus, raises a chip select, and pulses a write strobe. A separate end-of-packet strobe closes a short packet. The port samples all of these pins into its own clock domain through a synchronizer. A byte is stored on the trailing (deasserting) edge of the write strobe. The byte stored is the last one sampled while the strobe was still high, and the channel's write pointer advances after the store.

Each channel keeps a full flag and a running count of the bytes written since its last commit. When the end-of-packet strobe is released, the port offers a commit record on a valid/ready handshake. The record carries the channel index and the packet length, and the channel's packet counter restarts from zero. The master can misuse the strobes in several ways: end-of-packet overlapping a write, an address change while end-of-packet is held, a write into a full channel, or a second end-of-packet while a commit is still unaccepted. Each of these raises a sticky protocol-error output, and a misused commit is suppressed. A simple pop port lets the transfer side drain stored bytes in order.

Top module: `sfw_write_port`

## Requirements
- R1: After synchronous reset, `full_flags` is all zero, `cmt_valid` is 0, `proto_err` is 0 and `pop_empty` is 1 for every channel.
- R2: A byte is stored into the channel given by `bus_addr` when the write strobe deasserts. The stored value is the byte present while the strobe was high. Bytes come out of `pop_data` in write order: `pop_en` removes the head of channel `pop_sel`, and it is ignored when that channel is empty.
- R3: When a write fills a channel to DEPTH bytes, its bit in `full_flags` goes high on exactly the third rising clock edge after the write strobe falls, and not on the second. The bit clears on the edge that pops a byte from that channel.
- R4: A write strobe or end-of-packet strobe given while `bus_sel` is low has no effect: nothing is stored, and no commit or error is produced.
- R5: A write into a full channel is dropped and does not change the stored data or the packet length. It sets `proto_err`.
- R6: When the end-of-packet strobe deasserts, `cmt_valid` rises on the third rising clock edge. `cmt_fifo` carries the channel address held during the strobe and `cmt_len` carries the bytes stored in that channel since its previous commit. That channel's count then restarts from 0.
- R7: End-of-packet on a channel that has no bytes since its last commit produces a commit with `cmt_len` = 0.
- R8: `cmt_valid`, `cmt_fifo` and `cmt_len` hold steady until a cycle in which `cmt_ready` is high. `cmt_valid` drops on that edge.
- R9: If the write strobe is high in any cycle while the end-of-packet strobe is high, `proto_err` is set and no commit is produced. The write itself is stored, and the channel's packet count keeps it.
- R10: If `bus_addr` changes while the end-of-packet strobe is high, `proto_err` is set and no commit is produced.
- R11: End-of-packet that ends while a commit is still pending sets `proto_err` and is dropped. The pending record stays unchanged.
- R12: `proto_err` stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 1 | Chip select from the master, active high |
| bus_addr | input | FIFO_AW | Channel address from the master |
| bus_wr | input | 1 | Write strobe, active high; the byte is stored on its falling edge |
| bus_pkt_end | input | 1 | End-of-packet strobe, active high; the commit happens on its falling edge |
| bus_data | input | DATA_W | Byte data bus |
| pop_sel | input | FIFO_AW | Channel drained by the pop port |
| pop_en | input | 1 | Removes the head byte of channel `pop_sel` |
| pop_data | output | DATA_W | Head byte of channel `pop_sel` |
| pop_empty | output | 1 | Channel `pop_sel` holds no bytes |
| full_flags | output | 2**FIFO_AW | One full flag per channel |
| cmt_valid | output | 1 | A commit record is offered |
| cmt_ready | input | 1 | The consumer accepts the commit record |
| cmt_fifo | output | FIFO_AW | Channel of the committed packet |
| cmt_len | output | LEN_W | Byte count of the committed packet |
| proto_err | output | 1 | Sticky protocol-violation flag |

## Verification
A write pointer that slips by one shows up at `pop_data` on the next pop as a byte out of order or a stale byte. A packet counter that fails to clear or fails to count shows up in `cmt_len` on the very next commit. Wrong tracking of the end-of-packet state shows up three edges after the strobe falls: either `cmt_valid` rises when it should stay low, or `proto_err` stays low when it should rise. An occupancy count that is off appears as a full flag one write early or late. The bench checks that flag at the exact edge.

// File: rtl/sfw_pkg.sv
package sfw_pkg;

    // Bits needed to index n entries, never less than one.
    function automatic int unsigned idx_width(int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

    // Tracking of an end-of-packet strobe in flight.
    typedef enum logic [1:0] {
        PE_IDLE    = 2'd0,
        PE_ACTIVE  = 2'd1,
        PE_TAINTED = 2'd2
    } pe_state_e;

    // Number of synchronizer stages before the edge detector.
    localparam int unsigned SYNC_STAGES = 2;

endpackage

// File: rtl/sfw_sync.sv
module sfw_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] lvl,
    output logic [W-1:0] prev
);
    import sfw_pkg::*;

    logic [W-1:0] stage [SYNC_STAGES+1];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i <= SYNC_STAGES; i++) stage[i] <= '0;
        end else begin
            stage[0] <= din;
            for (int i = 1; i <= SYNC_STAGES; i++) stage[i] <= stage[i-1];
        end
    end

    assign lvl  = stage[SYNC_STAGES-1];
    assign prev = stage[SYNC_STAGES];

endmodule

// File: rtl/sfw_lane.sv
module sfw_lane #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [DATA_W-1:0] din,
    input  logic              pop,
    output logic [DATA_W-1:0] dout,
    output logic              full,
    output logic              empty
);
    import sfw_pkg::*;

    localparam int PW = idx_width(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PW-1:0]     wptr, rptr;
    logic [CW-1:0]     fill, fill_nx;

    function automatic logic [PW-1:0] advance(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        fill_nx = fill;
        if (push && !pop) fill_nx = fill + 1'b1;
        if (pop && !push) fill_nx = fill - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (push) mem[wptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr <= '0;
            rptr <= '0;
            fill <= '0;
            full <= 1'b0;
        end else begin
            if (push) wptr <= advance(wptr);
            if (pop)  rptr <= advance(rptr);
            fill <= fill_nx;
            full <= (fill_nx == CW'(DEPTH));
        end
    end

    assign dout  = mem[rptr];
    assign empty = (fill == '0);

    // R5: the write decoder never pushes into a full lane
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);

    // R2: the pop decoder never drains an empty lane
    p_no_underflow_r2: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);

    // R3: occupancy stays inside the lane
    p_fill_range_r3: assert property (@(posedge clk) disable iff (rst)
        fill <= CW'(DEPTH));

    // R3: a push into a lane one short of capacity raises full next edge
    p_full_rise_r3: assert property (@(posedge clk) disable iff (rst)
        (push && !pop && fill == CW'(DEPTH - 1)) |=> full);

endmodule

// File: rtl/sfw_commit.sv
module sfw_commit #(
    parameter int FIFO_AW = 1,
    parameter int LEN_W   = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pe_lvl,
    input  logic               pe_prev,
    input  logic               wr_lvl,
    input  logic [FIFO_AW-1:0] addr_lvl,
    input  logic               stored,
    input  logic [FIFO_AW-1:0] stored_fifo,
    input  logic               overflow,
    input  logic               cmt_ready,
    output logic               cmt_valid,
    output logic [FIFO_AW-1:0] cmt_fifo,
    output logic [LEN_W-1:0]   cmt_len,
    output logic               proto_err
);
    import sfw_pkg::*;

    localparam int NF = 1 << FIFO_AW;

    pe_state_e          st;
    logic [FIFO_AW-1:0] pe_addr;
    logic [LEN_W-1:0]   pkt_cnt [NF];
    logic               pe_rise, pe_fall, bad_end, good_end;

    assign pe_rise  = pe_lvl && !pe_prev;
    assign pe_fall  = !pe_lvl && pe_prev;
    assign bad_end  = pe_fall && (st == PE_TAINTED || cmt_valid);
    assign good_end = pe_fall && !bad_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= PE_IDLE;
            pe_addr <= '0;
        end else if (pe_rise) begin
            st      <= wr_lvl ? PE_TAINTED : PE_ACTIVE;
            pe_addr <= addr_lvl;
        end else if (pe_fall) begin
            st <= PE_IDLE;
        end else if (st == PE_ACTIVE && (wr_lvl || addr_lvl != pe_addr)) begin
            st <= PE_TAINTED;
        end
    end

    for (genvar i = 0; i < NF; i++) begin : g_cnt
        always_ff @(posedge clk) begin
            if (rst) begin
                pkt_cnt[i] <= '0;
            end else if (good_end && pe_addr == FIFO_AW'(i)) begin
                pkt_cnt[i] <= '0;
            end else if (stored && stored_fifo == FIFO_AW'(i) && pkt_cnt[i] != '1) begin
                pkt_cnt[i] <= pkt_cnt[i] + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmt_valid <= 1'b0;
            cmt_fifo  <= '0;
            cmt_len   <= '0;
            proto_err <= 1'b0;
        end else begin
            if (good_end) begin
                cmt_valid <= 1'b1;
                cmt_fifo  <= pe_addr;
                cmt_len   <= pkt_cnt[pe_addr];
            end else if (cmt_valid && cmt_ready) begin
                cmt_valid <= 1'b0;
            end
            if (overflow || bad_end) proto_err <= 1'b1;
        end
    end

    // R8: an offered record holds until accepted
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (cmt_valid && !cmt_ready) |=> (cmt_valid && $stable(cmt_fifo) && $stable(cmt_len)));

    // R12: the error flag never falls outside reset
    p_sticky_r12: assert property (@(posedge clk) disable iff (rst)
        proto_err |=> proto_err);

    // R9: a tainted end-of-packet never yields a fresh commit
    p_no_tainted_commit_r9: assert property (@(posedge clk) disable iff (rst)
        (pe_fall && st == PE_TAINTED && !cmt_valid) |=> !cmt_valid);

    // R11: a pending record is not replaced by a second end-of-packet
    p_pending_kept_r11: assert property (@(posedge clk) disable iff (rst)
        (pe_fall && cmt_valid && !cmt_ready) |=> (cmt_valid && $stable(cmt_len)));

endmodule

// File: rtl/sfw_write_port.sv
module sfw_write_port #(
    parameter int FIFO_AW = 1,
    parameter int DEPTH   = 8,
    parameter int DATA_W  = 8,
    parameter int LEN_W   = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      bus_sel,
    input  logic [FIFO_AW-1:0]        bus_addr,
    input  logic                      bus_wr,
    input  logic                      bus_pkt_end,
    input  logic [DATA_W-1:0]         bus_data,
    input  logic [FIFO_AW-1:0]        pop_sel,
    input  logic                      pop_en,
    output logic [DATA_W-1:0]         pop_data,
    output logic                      pop_empty,
    output logic [(1<<FIFO_AW)-1:0]   full_flags,
    output logic                      cmt_valid,
    input  logic                      cmt_ready,
    output logic [FIFO_AW-1:0]        cmt_fifo,
    output logic [LEN_W-1:0]          cmt_len,
    output logic                      proto_err
);
    localparam int NF = 1 << FIFO_AW;

    typedef struct packed {
        logic               wr;
        logic               pe;
        logic [FIFO_AW-1:0] addr;
        logic [DATA_W-1:0]  data;
    } bus_t;

    localparam int BW = $bits(bus_t);

    bus_t raw, cur, prv;
    logic [BW-1:0] cur_v, prv_v;

    // Strobes count only while selected
    assign raw = '{wr: bus_wr & bus_sel, pe: bus_pkt_end & bus_sel,
                   addr: bus_addr, data: bus_data};

    sfw_sync #(.W(BW)) u_sync (
        .clk (clk),
        .rst (rst),
        .din (raw),
        .lvl (cur_v),
        .prev(prv_v)
    );

    assign cur = bus_t'(cur_v);
    assign prv = bus_t'(prv_v);

    // Trailing edge of the write strobe; fields come from the last high sample
    logic wr_evt, stored, overflow;
    logic [NF-1:0] lane_full, lane_empty, lane_push, lane_pop;
    logic [DATA_W-1:0] lane_dout [NF];

    assign wr_evt   = prv.wr && !cur.wr;
    assign overflow = wr_evt && lane_full[prv.addr];
    assign stored   = wr_evt && !lane_full[prv.addr];

    for (genvar i = 0; i < NF; i++) begin : g_lane
        assign lane_push[i] = stored && prv.addr == FIFO_AW'(i);
        assign lane_pop[i]  = pop_en && pop_sel == FIFO_AW'(i) && !lane_empty[i];

        sfw_lane #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_lane (
            .clk  (clk),
            .rst  (rst),
            .push (lane_push[i]),
            .din  (prv.data),
            .pop  (lane_pop[i]),
            .dout (lane_dout[i]),
            .full (lane_full[i]),
            .empty(lane_empty[i])
        );
    end

    assign full_flags = lane_full;
    assign pop_data   = lane_dout[pop_sel];
    assign pop_empty  = lane_empty[pop_sel];

    sfw_commit #(.FIFO_AW(FIFO_AW), .LEN_W(LEN_W)) u_commit (
        .clk        (clk),
        .rst        (rst),
        .pe_lvl     (cur.pe),
        .pe_prev    (prv.pe),
        .wr_lvl     (cur.wr),
        .addr_lvl   (cur.addr),
        .stored     (stored),
        .stored_fifo(prv.addr),
        .overflow   (overflow),
        .cmt_ready  (cmt_ready),
        .cmt_valid  (cmt_valid),
        .cmt_fifo   (cmt_fifo),
        .cmt_len    (cmt_len),
        .proto_err  (proto_err)
    );

    // R4: nothing is stored in a cycle without a strobe trailing edge
    p_store_needs_edge_r4: assert property (@(posedge clk) disable iff (rst)
        (|lane_push) |-> (prv.wr && !cur.wr));

    // R5: a dropped write raises the error flag on the next edge
    p_drop_flags_r5: assert property (@(posedge clk) disable iff (rst)
        overflow |=> proto_err);

endmodule

// File: tb/tb_sfw_write_port.sv
module tb_sfw_write_port;
    localparam int FIFO_AW = 1;
    localparam int NF      = 2;
    localparam int DEPTH   = 8;

    logic       clk = 1'b0;
    logic       rst;
    logic       bus_sel, bus_wr, bus_pkt_end, pop_en, cmt_ready;
    logic [0:0] bus_addr, pop_sel, cmt_fifo;
    logic [7:0] bus_data, pop_data, cmt_len;
    logic       pop_empty, cmt_valid, proto_err;
    logic [1:0] full_flags;

    sfw_write_port #(.FIFO_AW(FIFO_AW), .DEPTH(DEPTH), .DATA_W(8), .LEN_W(8)) dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_pkt_end(bus_pkt_end), .bus_data(bus_data), .pop_sel(pop_sel), .pop_en(pop_en),
        .pop_data(pop_data), .pop_empty(pop_empty), .full_flags(full_flags),
        .cmt_valid(cmt_valid), .cmt_ready(cmt_ready), .cmt_fifo(cmt_fifo),
        .cmt_len(cmt_len), .proto_err(proto_err)
    );

    always #5 clk = ~clk;

    int checks = 0, fails = 0;
    bit done = 0;

    // Reference model
    int mq [NF][DEPTH];
    int mh [NF], mc [NF], mp [NF];
    bit merr, mpend;
    int mpf, mpl;

    function automatic int exp_full(int f);
        return (mc[f] == DEPTH) ? 1 : 0;
    endfunction

    function automatic int exp_head(int f);
        return mq[f][mh[f]];
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int f = 0; f < NF; f++) begin mh[f] = 0; mc[f] = 0; mp[f] = 0; end
        merr = 0; mpend = 0;
    endtask

    task automatic do_reset();
        rst = 1; bus_sel = 0; bus_wr = 0; bus_pkt_end = 0; bus_addr = 0; bus_data = 0;
        pop_sel = 0; pop_en = 0; cmt_ready = 0;
        repeat (4) @(negedge clk);
        rst = 0;
        model_reset();
        @(negedge clk);
    endtask

    task automatic model_write(int f, int d);
        if (mc[f] == DEPTH) merr = 1;
        else begin
            mq[f][(mh[f] + mc[f]) % DEPTH] = d;
            mc[f]++; mp[f]++;
        end
    endtask

    task automatic wr_byte(int f, int d, bit sel);
        bus_addr = f[0]; bus_data = d[7:0]; bus_sel = sel;
        @(negedge clk); bus_wr = 1;
        repeat (3) @(negedge clk); bus_wr = 0;
        repeat (4) @(negedge clk);
        bus_sel = 0;
        if (sel) model_write(f, d);
    endtask

    task automatic pkt_end(int f);
        bus_addr = f[0]; bus_sel = 1;
        @(negedge clk); bus_pkt_end = 1;
        repeat (3) @(negedge clk); bus_pkt_end = 0;
        repeat (3) @(negedge clk);
        bus_sel = 0;
        if (mpend) merr = 1;
        else begin mpend = 1; mpf = f; mpl = mp[f]; mp[f] = 0; end
    endtask

    task automatic accept(string req);
        chk({req, " cmt_valid"}, cmt_valid, 1);
        chk({req, " cmt_fifo"}, cmt_fifo, mpf);
        chk({req, " cmt_len"}, cmt_len, mpl);
        cmt_ready = 1; @(negedge clk); cmt_ready = 0;
        chk("R8 valid drops after accept", cmt_valid, 0);
        mpend = 0;
    endtask

    task automatic pop_chk(int f, string req);
        pop_sel = f[0];
        #1;
        chk({req, " pop_empty"}, pop_empty, 0);
        chk({req, " pop_data"}, pop_data, exp_head(f));
        pop_en = 1; @(negedge clk); pop_en = 0;
        mh[f] = (mh[f] + 1) % DEPTH; mc[f]--;
        chk("R3 full flag after pop", full_flags[f], exp_full(f));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int seed_v;
        seed_v = $urandom(32'h5EED_0A17);
        do_reset();

        // R1 reset state
        chk("R1 full_flags", full_flags, 0);
        chk("R1 cmt_valid", cmt_valid, 0);
        chk("R1 proto_err", proto_err, 0);
        for (int f = 0; f < NF; f++) begin
            pop_sel = f[0]; #1; chk("R1 pop_empty", pop_empty, 1);
        end

        // R2 R6 four-byte short packet, then ordered drain
        for (int i = 0; i < 4; i++) wr_byte(0, 8'hA1 + i, 1);
        pkt_end(0);
        accept("R6 short packet");
        for (int i = 0; i < 4; i++) pop_chk(0, "R2 ordered drain");
        pop_sel = 0; #1; chk("R2 drained empty", pop_empty, 1);
        pop_en = 1; @(negedge clk); pop_en = 0;   // pop on empty ignored
        #1; chk("R2 pop on empty ignored", pop_empty, 1);

        // R7 zero-length commit
        pkt_end(1);
        accept("R7 zero length");

        // R4 deselected strobes ignored
        wr_byte(0, 8'h5C, 0);
        pop_sel = 0; #1; chk("R4 deselected write not stored", pop_empty, 1);
        bus_addr = 1; bus_sel = 0; @(negedge clk); bus_pkt_end = 1;
        repeat (3) @(negedge clk); bus_pkt_end = 0; repeat (4) @(negedge clk);
        chk("R4 deselected pkt end no commit", cmt_valid, 0);
        chk("R4 no error", proto_err, 0);
        pkt_end(0);
        accept("R4 count unchanged by deselected write");

        // R3 full flag latency on channel 1
        for (int i = 0; i < DEPTH - 1; i++) wr_byte(1, 8'h10 + i, 1);
        chk("R3 not full one short", full_flags[1], 0);
        bus_addr = 1; bus_data = 8'h77; bus_sel = 1;
        @(negedge clk); bus_wr = 1; repeat (3) @(negedge clk); bus_wr = 0;
        repeat (2) @(negedge clk);
        chk("R3 full not yet at second edge", full_flags[1], 0);
        @(negedge clk);
        chk("R3 full at third edge", full_flags[1], 1);
        repeat (2) @(negedge clk); bus_sel = 0;
        model_write(1, 8'h77);
        pop_chk(1, "R3 pop from full");
        pkt_end(1);
        accept("R6 full packet length");
        for (int i = 0; i < DEPTH - 1; i++) pop_chk(1, "R2 drain channel 1");

        // Randomized traffic
        for (int n = 0; n < 400; n++) begin
            int op, f;
            op = $urandom_range(0, 9);
            f  = $urandom_range(0, NF - 1);
            if (op < 5) begin
                if (mc[f] < DEPTH) wr_byte(f, $urandom_range(0, 255), 1);
                else pop_chk(f, "R2 random pop");
            end else if (op < 7) begin
                if (mc[f] > 0) pop_chk(f, "R2 random pop");
            end else if (op < 9) begin
                if (mpend) accept("R6 random commit");
                else begin
                    pkt_end(f);
                    if ($urandom_range(0, 1) == 1) accept("R6 random commit");
                end
            end else if (mpend) begin
                chk("R8 pending held", cmt_valid, 1);
                chk("R8 pending len stable", cmt_len, mpl);
            end
            chk("R3 random full flag", full_flags[f], exp_full(f));
        end
        if (mpend) accept("R6 final commit");
        chk("R12 no error on clean traffic", proto_err, 0);

        // R5 overflow drops the byte and flags an error
        do_reset();
        for (int i = 0; i < DEPTH; i++) wr_byte(1, 8'h30 + i, 1);
        chk("R5 no error before overflow", proto_err, 0);
        wr_byte(1, 8'hEE, 1);
        chk("R5 overflow error", proto_err, 1);
        pop_chk(1, "R5 data intact");
        pkt_end(1);
        accept("R5 length excludes dropped byte");
        chk("R12 error sticky after commit", proto_err, 1);

        // R9 write overlapping packet end
        do_reset();
        wr_byte(0, 8'h41, 1);
        bus_addr = 0; bus_data = 8'h42; bus_sel = 1;
        @(negedge clk); bus_wr = 1; bus_pkt_end = 1;
        repeat (3) @(negedge clk); bus_wr = 0; bus_pkt_end = 0;
        repeat (4) @(negedge clk); bus_sel = 0;
        model_write(0, 8'h42);
        chk("R9 overlap no commit", cmt_valid, 0);
        chk("R9 overlap error", proto_err, 1);
        pkt_end(0);
        accept("R9 count kept after suppressed commit");

        // R10 address change during packet end
        do_reset();
        wr_byte(1, 8'h55, 1);
        bus_addr = 1; bus_sel = 1; @(negedge clk); bus_pkt_end = 1;
        repeat (2) @(negedge clk); bus_addr = 0;
        repeat (4) @(negedge clk); bus_pkt_end = 0;
        repeat (4) @(negedge clk); bus_sel = 0;
        chk("R10 address change no commit", cmt_valid, 0);
        chk("R10 address change error", proto_err, 1);

        // R11 second packet end while pending
        do_reset();
        wr_byte(0, 8'h61, 1);
        wr_byte(0, 8'h62, 1);
        pkt_end(0);
        wr_byte(0, 8'h63, 1);
        pkt_end(0);
        chk("R11 error on pending", proto_err, 1);
        accept("R11 pending record unchanged");
        repeat (5) @(negedge clk);
        chk("R12 error still set", proto_err, 1);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial if (seed_dummy() != 0) ;
    function automatic int seed_dummy();
        return 0;
    endfunction

endmodule